// File: doc/BRIEF.md
# Energy Dispersal Descrambler

This block strips the energy-dispersal randomization from transport packets once outer decoding has finished. A 15-stage pseudo-random generator built on x^15 + x^14 + 1 produces one keystream byte per payload byte, and that byte is XORed onto the data. An upstream framer supplies a packet-start flag and a flag that marks the start byte as inverted. An inverted start byte opens a randomization group: it reseeds the generator and leaves the block as the ordinary sync value. The block does not detect packet framing itself, and it does not correct errors.

There is a bypass input that forwards every byte unchanged. In bypass the generator keeps its sequence exactly as it would in normal operation, so bypass can be switched on or off at any byte without losing alignment. Each result appears one clock after the input byte that produced it.

Top module: `ed_descrambler`

## Requirements
- R1: While reset is active and on the first cycle after it, `out_valid` and `out_start` are 0 and `out_byte` is 0x00. The generator holds the seed.
- R2: The generator stages are numbered 1 to 15. On each step, stage 14 XOR stage 15 enters stage 1 and every other stage moves one position up. A payload byte takes 8 steps. The first step's value is the byte's bit 7, and the byte is output as input XOR keystream.
- R3: A byte with `in_start`=1 and `in_inv`=1 loads the seed 100101010000000 (stage 1 written leftmost). The generator does not step for that byte, and the byte is output bitwise complemented.
- R4: A byte with `in_start`=1 and `in_inv`=0 is output unchanged, and the generator advances 8 steps.
- R5: The first payload byte after an inverted start byte is XORed with 0x03.
- R6: With `bypass`=1, every byte is output unchanged, including inverted start bytes. The generator reloads and advances exactly as it does with `bypass`=0.
- R7: A cycle with `in_valid`=0 leaves the generator unchanged. It drives `out_valid`=0 on the next cycle, and `out_byte` keeps its last value.
- R8: `out_valid` and `out_start` are `in_valid` and `in_valid AND in_start` delayed by one clock. `out_byte` follows the same one-clock timing.
- R9: `in_inv` has no effect when `in_start` is 0. Such a byte is treated as payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Forward data unchanged |
| in_byte | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is valid |
| in_start | input | 1 | Byte is a packet start (sync) byte |
| in_inv | input | 1 | Start byte is inverted (group start) |
| out_byte | output | 8 | Descrambled byte |
| out_valid | output | 1 | Output byte is valid |
| out_start | output | 1 | Output byte is a packet start byte |

## Verification
Two functions can fall on the same byte: the seed reload and the bypass path. In bypass the generator must reseed even though the data is not touched. The bench provokes this by sending whole randomization groups in bypass, and by switching bypass on alternate bytes, inverted start bytes included. The test then turns bypass off on the following bytes and compares their keystream with a model that never skipped a reload. A stray `in_inv` on a payload byte is also sent, which checks that the reload fires only together with a start byte.

// File: rtl/ed_pkg.sv
package ed_pkg;
  localparam int LFSR_W = 15;
  localparam int BYTE_W = 8;
  localparam logic [LFSR_W-1:0] SEED = 15'b000_0000_1010_1001; // stage1 = bit0

  typedef struct packed {
    logic [BYTE_W-1:0] key;
    logic [LFSR_W-1:0] next;
  } step_t;

  // one generator step: stage14 ^ stage15 enters stage1 (bit0)
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-2] ^ s[LFSR_W-1]};
  endfunction

  // BYTE_W steps, first produced bit lands in the MSB of the key
  function automatic step_t lfsr_byte(input logic [LFSR_W-1:0] s);
    step_t r;
    logic [LFSR_W-1:0] st;
    st = s;
    r.key = '0;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      r.key[i] = st[LFSR_W-2] ^ st[LFSR_W-1];
      st = lfsr_step(st);
    end
    r.next = st;
    return r;
  endfunction
endpackage

// File: rtl/ed_prbs_gen.sv
module ed_prbs_gen
  import ed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              advance,
  output logic [LFSR_W-1:0] state_o,
  output logic [BYTE_W-1:0] key_o
);
  step_t nxt;
  logic [LFSR_W-1:0] state_q;

  always_comb nxt = lfsr_byte(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= SEED;
    else if (reload)  state_q <= SEED;
    else if (advance) state_q <= nxt.next;
  end

  assign state_o = state_q;
  assign key_o   = nxt.key;
endmodule

// File: rtl/ed_byte_path.sv
module ed_byte_path
  import ed_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  input  logic [BYTE_W-1:0] key,
  input  logic              is_start,
  input  logic              is_inv,
  input  logic              bypass,
  output logic [BYTE_W-1:0] dout
);
  always_comb begin
    if (bypass)                 dout = din;
    else if (is_start && is_inv) dout = ~din;
    else if (is_start)           dout = din;
    else                         dout = din ^ key;
  end
endmodule

// File: rtl/ed_descrambler.sv
module ed_descrambler
  import ed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_inv,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              out_start
);
  // named internal events for the checker
  logic              ev_reload;
  logic              ev_advance;
  logic [LFSR_W-1:0] gen_state;
  logic [BYTE_W-1:0] gen_key;
  logic [BYTE_W-1:0] path_byte;

  assign ev_reload  = in_valid && in_start && in_inv;
  assign ev_advance = in_valid && !ev_reload;

  ed_prbs_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (ev_reload),
    .advance (ev_advance),
    .state_o (gen_state),
    .key_o   (gen_key)
  );

  ed_byte_path u_path (
    .din      (in_byte),
    .key      (gen_key),
    .is_start (in_start),
    .is_inv   (in_inv),
    .bypass   (bypass),
    .dout     (path_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_start <= in_valid && in_start;
      if (in_valid) out_byte <= path_byte;
    end
  end
endmodule

// File: rtl/ed_descrambler_chk.sv
module ed_descrambler_chk
  import ed_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bypass,
  input logic [BYTE_W-1:0] in_byte,
  input logic              in_valid,
  input logic              in_start,
  input logic              in_inv,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_valid,
  input logic              out_start,
  input logic [LFSR_W-1:0] gen_state
);
  assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_start_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_start == $past(in_valid && in_start)));

  assert_seed_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && in_inv) |=> (gen_state == SEED));

  assert_inv_sync_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && in_inv && !bypass) |=> (out_byte == ~$past(in_byte)));

  assert_plain_sync_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && !in_inv) |=> (out_byte == $past(in_byte)));

  assert_bypass_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> (out_byte == $past(in_byte)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(gen_state) && $stable(out_byte)));
endmodule

bind ed_descrambler ed_descrambler_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bypass    (bypass),
  .in_byte   (in_byte),
  .in_valid  (in_valid),
  .in_start  (in_start),
  .in_inv    (in_inv),
  .out_byte  (out_byte),
  .out_valid (out_valid),
  .out_start (out_start),
  .gen_state (gen_state)
);

// File: tb/ed_descrambler_bench.sv
`timescale 1ns/1ps
module ed_descrambler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bypass = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_start = 1'b0;
  logic       in_inv = 1'b0;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       out_start;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model: stage index 1..15, plain bit array
  bit         m [1:15];
  logic [7:0] exp_byte;

  always #5 clk = ~clk;

  ed_descrambler u_ed_descrambler (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_byte(in_byte),
    .in_valid(in_valid), .in_start(in_start), .in_inv(in_inv),
    .out_byte(out_byte), .out_valid(out_valid), .out_start(out_start)
  );

  task automatic seed_model();
    for (int k = 1; k <= 15; k++) m[k] = 0;
    m[1] = 1; m[4] = 1; m[6] = 1; m[8] = 1;
  endtask

  function automatic logic [7:0] model_key();
    logic [7:0] kb;
    bit f;
    for (int b = 0; b < 8; b++) begin
      f = m[14] ^ m[15];
      kb = {kb[6:0], f};
      for (int k = 15; k > 1; k--) m[k] = m[k-1];
      m[1] = f;
    end
    return kb;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register)
  task automatic send(input logic [7:0] b, input bit v, input bit st,
                      input bit inv, input bit byp, input string req);
    logic [7:0] kb;
    in_byte = b; in_valid = v; in_start = st; in_inv = inv; bypass = byp;
    if (v) begin
      if (st && inv) begin
        exp_byte = byp ? b : ~b;
        seed_model();
      end else if (st) begin
        exp_byte = b;
        kb = model_key();
      end else begin
        kb = model_key();
        exp_byte = byp ? b : (b ^ kb);
      end
    end
    @(negedge clk);
    chk({req, " valid"}, {31'd0, out_valid}, {31'd0, v});
    chk({req, " start"}, {31'd0, out_start}, {31'd0, v & st});
    chk({req, " byte"}, {24'd0, out_byte}, {24'd0, exp_byte});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    seed_model();
    exp_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 byte", {24'd0, out_byte}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {23'd0, out_valid, out_byte}, 32'd0);

    // R5: known first keystream byte
    send(8'h47, 1, 1, 1, 0, "R3 inv sync");
    send(8'h00, 1, 0, 0, 0, "R5 first key");
    chk("R5 literal", {24'd0, out_byte}, 32'h03);

    cnt = 0;
    for (int g = 0; g < 5; g++) begin
      for (int p = 0; p < 8; p++) begin
        bit gb;
        gb = (g == 2) || (g == 3 && p[0]);
        send(p == 0 ? 8'hB8 : 8'h47, 1, 1, p == 0, gb,
             p == 0 ? (gb ? "R6 inv sync bypass" : "R3 inv sync") : "R4 plain sync");
        for (int i = 0; i < 31; i++) begin
          bit byp;
          byp = (g == 2) || (g == 3 && i[0]);
          if (cnt % 5 == 4) send(8'h5A, 0, 0, 0, byp, "R7 idle");
          send(cnt[7:0], 1, 0, (g == 1 && i == 7), byp,
               (g == 1 && i == 7) ? "R9 stray inv" :
               (byp ? "R6 bypass" : "R2 payload"));
          cnt++;
        end
      end
    end
    send(8'h00, 0, 0, 0, 0, "R8 drain");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule